// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block sits behind the sync slicer of a video decoder. It watches a one-bit composite sync level (low while the sync tip is present), a strobe that marks each detected horizontal sync, and the current pixel position within the line. It reports the start of each vertical interval and classifies each field as odd or even. The vertical interval is found by measuring how long each sync pulse stays low. Ordinary line syncs are short. The broad pulses of the vertical interval are long, so the first pulse whose low time passes a programmable threshold marks the field start. The field parity comes from where in the line that crossing happens.

The block also watches for two fault conditions. If horizontal syncs stop, it runs a free line timer at the programmed line length, so that line timing continues, and it flags that no video is present. If no vertical interval turns up within a fixed budget of lines for one or three fields in a row, it declares vertical sync lost. It then keeps the field flag alternating and pulses a request that sends the timing loops back to acquisition. Two interrupt requests, each with its own enable, report each accepted vertical sync and the onset of the no-video condition.

Top module: `vsync_field_det`

## Requirements
- R1: A low-time count restarts at each rising edge of `sync_low_i`. `vsync_o` goes high at the clock edge where the current pulse has been low for `vdet_thresh_i`+1 cycles, counting that edge's cycle. A pulse low for only `vdet_thresh_i` cycles does not assert it.
- R2: At the edge where vertical sync is accepted, `field_o` becomes 1 (even) if `line_pos_i` >= `line_total_i`/2 (rounded down), and 0 (odd) otherwise.
- R3: `vsync_o` stays high for `VS_LINES` (default 3) line events, then clears. Threshold crossings while it is high are ignored and reset no counter.
- R4: `no_video_o` goes high after 16 consecutive internal line periods with no `hsync_i`. Any `hsync_i` clears it at the next edge.
- R5: `line_tick_o` is high when `hsync_i` is high. It is also high when no `hsync_i` has arrived for `line_total_i` cycles since the last line event, which gives a free-running line period. Each such cycle is one line event.
- R6: A field budget expires at every 337th line event after the last accepted vertical sync, or after the previous expiry. `lost_vsync_o` is set when 1 consecutive budget expires (`three_field_i`=0) or 3 expire (`three_field_i`=1). It clears when a vertical sync is accepted.
- R7: `field_o` inverts at every budget expiry. `pll_reacq_o` is a single-cycle pulse at the edge where `lost_vsync_o` becomes set.
- R8: `irq_vsync_o` pulses for one cycle together with the rise of `vsync_o` when `irq_vsync_en_i` is 1. `irq_novideo_o` pulses for one cycle together with the rise of `no_video_o` when `irq_novideo_en_i` is 1.
- R9: If a vertical sync is accepted at the same edge where a budget expires, the acceptance wins. `field_o` takes the parity from position, there is no inversion, the miss count is cleared and `lost_vsync_o` is not set.
- R10: While `rst_ni` is low, every output except `line_tick_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_low_i | input | 1 | Sliced composite sync, 1 while at sync tip |
| hsync_i | input | 1 | One-cycle strobe per detected horizontal sync |
| line_pos_i | input | PW | Pixel position within the current line |
| line_total_i | input | PW | Total pixels per line |
| vdet_thresh_i | input | CW | Low-time threshold for vertical detection |
| three_field_i | input | 1 | 0: lose vsync after 1 missed field, 1: after 3 |
| irq_vsync_en_i | input | 1 | Enable for the vertical sync interrupt |
| irq_novideo_en_i | input | 1 | Enable for the no-video interrupt |
| vsync_o | output | 1 | Vertical sync indication |
| field_o | output | 1 | Field parity, 0 odd, 1 even |
| line_tick_o | output | 1 | Line event: real or free-running horizontal sync |
| no_video_o | output | 1 | Horizontal syncs absent for 16 lines |
| lost_vsync_o | output | 1 | Vertical sync lost |
| pll_reacq_o | output | 1 | Pulse requesting timing-loop re-acquisition |
| irq_vsync_o | output | 1 | Vertical sync interrupt pulse |
| irq_novideo_o | output | 1 | No-video interrupt pulse |

## Verification
The case that needs care is a threshold crossing that arrives on the same edge as the 337th line event, where the vertical sync detector and the field-budget logic both want to update the field flag and the miss counter. The bench sets this up by holding the sync low from late in the line before the expiry, so that the crossing falls exactly on the hsync strobe that ends the budget. The field is odd before the collision, so a wrong winner shows up at once: an inverted field or a set loss flag marks the error. A cycle-level reference model computes all outputs from the rules on every cycle, while random pulse lengths, positions and thresholds run alongside the directed runs for each boundary.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int unsigned VFD_PW        = 10;
  localparam int unsigned VFD_CW        = 8;
  localparam int unsigned VFD_VS_LINES  = 3;
  localparam int unsigned VFD_BUDGET    = 337;
  localparam int unsigned VFD_MISS      = 16;

  typedef enum logic {FIELD_ODD = 1'b0, FIELD_EVEN = 1'b1} field_e;
endpackage

// File: rtl/vfd_lowtime.sv
module vfd_lowtime #(
  parameter int unsigned CW = vfd_pkg::VFD_CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_low_i,
  input  logic [CW-1:0] thresh_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          low_q, rise;

  assign rise = sync_low_i & ~low_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (rise)            cnt_nxt = CW'(1);
    else if (sync_low_i) cnt_nxt = (cnt_q == '1) ? cnt_q : cnt_q + CW'(1);
  end

  // first crossing within one pulse only
  assign hit_o = sync_low_i && (cnt_nxt > thresh_i) && (rise || !(cnt_q > thresh_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      low_q <= sync_low_i;
    end
  end
endmodule

// File: rtl/vfd_linewatch.sv
module vfd_linewatch #(
  parameter int unsigned PW   = vfd_pkg::VFD_PW,
  parameter int unsigned MISS = vfd_pkg::VFD_MISS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hsync_i,
  input  logic [PW-1:0] line_total_i,
  input  logic          irq_en_i,
  output logic          line_ev_o,
  output logic          no_video_o,
  output logic          irq_o
);
  localparam int unsigned MW = $clog2(MISS + 1);

  logic [PW-1:0] pix_q;
  logic [MW-1:0] miss_q;
  logic          tick;

  assign tick       = !hsync_i && (pix_q == line_total_i - PW'(1));
  assign line_ev_o  = hsync_i | tick;
  assign no_video_o = (miss_q == MW'(MISS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      miss_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= irq_en_i && tick && (miss_q == MW'(MISS - 1));
      pix_q <= line_ev_o ? '0 : pix_q + PW'(1);
      if (hsync_i)                             miss_q <= '0;
      else if (tick && miss_q != MW'(MISS))    miss_q <= miss_q + MW'(1);
    end
  end
endmodule

// File: rtl/vfd_fieldtrack.sv
module vfd_fieldtrack #(
  parameter int unsigned PW       = vfd_pkg::VFD_PW,
  parameter int unsigned VS_LINES = vfd_pkg::VFD_VS_LINES,
  parameter int unsigned BUDGET   = vfd_pkg::VFD_BUDGET
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          line_ev_i,
  input  logic [PW-1:0] line_pos_i,
  input  logic [PW-1:0] line_total_i,
  input  logic          three_field_i,
  input  logic          irq_en_i,
  output logic          vsync_o,
  output logic          field_o,
  output logic          lost_o,
  output logic          reacq_o,
  output logic          irq_o
);
  import vfd_pkg::*;
  localparam int unsigned LW = $clog2(BUDGET);
  localparam int unsigned VW = $clog2(VS_LINES + 1);

  logic [LW-1:0] lcnt_q;
  logic [VW-1:0] vsl_q;
  logic [1:0]    mf_q, mf_nxt, need;
  field_e        field_q;
  logic          det, expire;

  assign det    = hit_i && !vsync_o;
  assign expire = line_ev_i && (lcnt_q == LW'(BUDGET - 1));
  assign need   = three_field_i ? 2'd3 : 2'd1;
  assign mf_nxt = (mf_q == 2'd3) ? mf_q : mf_q + 2'd1;
  assign field_o = field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsync_o <= 1'b0;
      vsl_q   <= '0;
      field_q <= FIELD_ODD;
      lcnt_q  <= '0;
      mf_q    <= '0;
      lost_o  <= 1'b0;
      reacq_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      reacq_o <= 1'b0;
      irq_o   <= det && irq_en_i;
      if (det) begin
        vsync_o <= 1'b1;
        vsl_q   <= '0;
        field_q <= (line_pos_i >= (line_total_i >> 1)) ? FIELD_EVEN : FIELD_ODD;
        lcnt_q  <= '0;
        mf_q    <= '0;
        lost_o  <= 1'b0;
      end else begin
        if (vsync_o && line_ev_i) begin
          if (vsl_q == VW'(VS_LINES - 1)) vsync_o <= 1'b0;
          else                            vsl_q   <= vsl_q + VW'(1);
        end
        if (line_ev_i) lcnt_q <= expire ? '0 : lcnt_q + LW'(1);
        if (expire) begin
          field_q <= (field_q == FIELD_ODD) ? FIELD_EVEN : FIELD_ODD;
          mf_q    <= mf_nxt;
          if (mf_nxt >= need && !lost_o) begin
            lost_o  <= 1'b1;
            reacq_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det #(
  parameter int unsigned PW       = vfd_pkg::VFD_PW,
  parameter int unsigned CW       = vfd_pkg::VFD_CW,
  parameter int unsigned VS_LINES = vfd_pkg::VFD_VS_LINES,
  parameter int unsigned BUDGET   = vfd_pkg::VFD_BUDGET,
  parameter int unsigned MISS     = vfd_pkg::VFD_MISS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_low_i,
  input  logic          hsync_i,
  input  logic [PW-1:0] line_pos_i,
  input  logic [PW-1:0] line_total_i,
  input  logic [CW-1:0] vdet_thresh_i,
  input  logic          three_field_i,
  input  logic          irq_vsync_en_i,
  input  logic          irq_novideo_en_i,
  output logic          vsync_o,
  output logic          field_o,
  output logic          line_tick_o,
  output logic          no_video_o,
  output logic          lost_vsync_o,
  output logic          pll_reacq_o,
  output logic          irq_vsync_o,
  output logic          irq_novideo_o
);
  logic hit;

  vfd_lowtime #(.CW(CW)) u_low (
    .clk_i, .rst_ni, .sync_low_i, .thresh_i(vdet_thresh_i), .hit_o(hit)
  );

  vfd_linewatch #(.PW(PW), .MISS(MISS)) u_line (
    .clk_i, .rst_ni, .hsync_i, .line_total_i, .irq_en_i(irq_novideo_en_i),
    .line_ev_o(line_tick_o), .no_video_o, .irq_o(irq_novideo_o)
  );

  vfd_fieldtrack #(.PW(PW), .VS_LINES(VS_LINES), .BUDGET(BUDGET)) u_fld (
    .clk_i, .rst_ni, .hit_i(hit), .line_ev_i(line_tick_o), .line_pos_i,
    .line_total_i, .three_field_i, .irq_en_i(irq_vsync_en_i),
    .vsync_o, .field_o, .lost_o(lost_vsync_o), .reacq_o(pll_reacq_o),
    .irq_o(irq_vsync_o)
  );
endmodule

// File: rtl/vsync_field_det_chk.sv
module vsync_field_det_chk #(
  parameter int unsigned PW = vfd_pkg::VFD_PW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_low_i,
  input logic          hsync_i,
  input logic [PW-1:0] line_pos_i,
  input logic [PW-1:0] line_total_i,
  input logic          vsync_o,
  input logic          field_o,
  input logic          no_video_o,
  input logic          lost_vsync_o,
  input logic          pll_reacq_o,
  input logic          irq_vsync_o,
  input logic          irq_novideo_o
);
  AST_VS_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_low_i |=> !$rose(vsync_o)); // R1

  AST_FIELD_FROM_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> (field_o == ($past(line_pos_i) >= ($past(line_total_i) >> 1)))); // R2

  AST_HSYNC_CLEARS_NV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |=> !no_video_o); // R4

  AST_VS_CLEARS_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> !lost_vsync_o); // R6

  AST_REACQ_ON_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_reacq_o |-> $rose(lost_vsync_o)); // R7

  AST_IRQ_VS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_vsync_o |-> $rose(vsync_o)); // R8

  AST_IRQ_NV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_novideo_o |-> $rose(no_video_o)); // R8
endmodule

bind vsync_field_det vsync_field_det_chk #(.PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_low_i(sync_low_i), .hsync_i(hsync_i),
  .line_pos_i(line_pos_i), .line_total_i(line_total_i), .vsync_o(vsync_o),
  .field_o(field_o), .no_video_o(no_video_o), .lost_vsync_o(lost_vsync_o),
  .pll_reacq_o(pll_reacq_o), .irq_vsync_o(irq_vsync_o), .irq_novideo_o(irq_novideo_o)
);

// File: tb/vsync_field_det_test.sv
module vsync_field_det_test;
  localparam int PW = 10;
  localparam int CW = 8;
  localparam int T  = 20;

  logic          clk, rst_n;
  logic          s_low, hs, three, en_v, en_n;
  logic [PW-1:0] pos, tot;
  logic [CW-1:0] thr;
  logic vs, fld, ltick, nv, lost, reacq, irqv, irqn;

  vsync_field_det uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_low_i(s_low), .hsync_i(hs),
    .line_pos_i(pos), .line_total_i(tot), .vdet_thresh_i(thr),
    .three_field_i(three), .irq_vsync_en_i(en_v), .irq_novideo_en_i(en_n),
    .vsync_o(vs), .field_o(fld), .line_tick_o(ltick), .no_video_o(nv),
    .lost_vsync_o(lost), .pll_reacq_o(reacq), .irq_vsync_o(irqv),
    .irq_novideo_o(irqn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errs = 0, checks = 0;
  bit running = 0, done = 0;

  task automatic chk(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // reference model
  int m_run, m_pix, m_miss, m_lcnt, m_vsl, m_mf;
  bit m_vs, m_fld, m_lost, m_reacq, m_irqv, m_irqn;

  always @(posedge clk) begin
    bit tick, lev, hit, det, expv;
    if (!rst_n) begin
      m_run = 0; m_pix = 0; m_miss = 0; m_lcnt = 0; m_vsl = 0; m_mf = 0;
      m_vs = 0; m_fld = 0; m_lost = 0; m_reacq = 0; m_irqv = 0; m_irqn = 0;
    end else begin
      tick = !hs && (m_pix == int'(tot) - 1);
      lev  = hs || tick;
      m_run = s_low ? m_run + 1 : 0;
      hit  = s_low && (m_run == int'(thr) + 1);
      det  = hit && !m_vs;
      m_irqn = en_n && tick && (m_miss == 15);
      if (hs) m_miss = 0; else if (tick && m_miss < 16) m_miss++;
      m_pix = lev ? 0 : m_pix + 1;
      m_reacq = 0;
      m_irqv = det && en_v;
      expv = lev && (m_lcnt == 336);
      if (det) begin
        m_vs = 1; m_vsl = 0; m_fld = (int'(pos) >= int'(tot) / 2);
        m_lcnt = 0; m_mf = 0; m_lost = 0;
      end else begin
        if (m_vs && lev) begin
          if (m_vsl == 2) m_vs = 0; else m_vsl++;
        end
        if (lev) m_lcnt = expv ? 0 : m_lcnt + 1;
        if (expv) begin
          m_fld = !m_fld;
          if (m_mf < 3) m_mf++;
          if (m_mf >= (three ? 3 : 1) && !m_lost) begin m_lost = 1; m_reacq = 1; end
        end
      end
    end
    #6;
    if (running && !done) begin
      chk("R1", "vsync_o", vs, m_vs);
      chk("R2", "field_o", fld, m_fld);
      chk("R5", "line_tick_o", ltick, hs || (!hs && m_pix == int'(tot) - 1));
      chk("R4", "no_video_o", nv, m_miss == 16);
      chk("R6", "lost_vsync_o", lost, m_lost);
      chk("R7", "pll_reacq_o", reacq, m_reacq);
      chk("R8", "irq_vsync_o", irqv, m_irqv);
      chk("R8", "irq_novideo_o", irqn, m_irqn);
    end
  end

  // drive one line from position p0; bst/blen: extra low pulse; pre: low from this position to line end
  task automatic drive_line(input int p0, input bit hs_on, input int bst, input int blen, input int pre);
    for (int p = p0; p < T; p++) begin
      @(negedge clk);
      hs    = hs_on && (p == 0);
      pos   = PW'(p);
      s_low = (hs_on && p < 3) || (p >= bst && p < bst + blen) || (p >= pre);
    end
  endtask

  task automatic plain_lines(input int n);
    for (int i = 0; i < n; i++) drive_line(0, 1, 99, 0, 99);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; s_low = 0; hs = 0; pos = '0; tot = PW'(T); thr = CW'(3);
    three = 0; en_v = 1; en_n = 1;
    repeat (4) @(negedge clk);
    chk("R10", "reset vsync_o", vs, 0);
    chk("R10", "reset field_o", fld, 0);
    chk("R10", "reset no_video_o", nv, 0);
    chk("R10", "reset lost_vsync_o", lost, 0);
    chk("R10", "reset irq", irqv | irqn | reacq, 0);
    running = 1;
    @(negedge clk); rst_n = 1;
    plain_lines(4);

    // R1 boundary: low for exactly thr cycles, then thr+1
    thr = CW'(4);
    drive_line(0, 1, 5, 4, 99);
    chk("R1", "no vsync at len=thr", vs, 0);
    drive_line(0, 1, 5, 5, 99);  // crossing at pos 9: odd
    chk("R1", "vsync at len=thr+1", vs, 1);
    chk("R2", "odd field", fld, 0);
    drive_line(0, 1, 11, 8, 99); // ignored while high (R3)
    chk("R3", "hold during vsync", vs, 1);
    plain_lines(4);
    chk("R3", "vsync cleared", vs, 0);
    drive_line(0, 1, 6, 5, 99);  // crossing at pos 10 = half: even
    chk("R2", "even at half", fld, 1);
    plain_lines(4);

    // random mix
    for (int i = 0; i < 150; i++) begin
      if (i % 25 == 0) thr = CW'(3 + $urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0)
        drive_line(0, 1, $urandom_range(3, 14), int'(thr) - 1 + $urandom_range(0, 4), 99);
      else
        drive_line(0, 1, 99, 0, 99);
    end
    plain_lines(4);

    // R4 no video
    for (int i = 0; i < 18; i++) drive_line(0, 0, 99, 0, 99);
    chk("R4", "no_video set", nv, 1);
    plain_lines(1);
    chk("R4", "no_video cleared", nv, 0);

    // R6 one-field loss
    thr = CW'(3); three = 0;
    drive_line(0, 1, 4, 6, 99);
    plain_lines(340);
    chk("R6", "lost after 1 field", lost, 1);
    // R6 three-field loss
    three = 1;
    drive_line(0, 1, 4, 6, 99);
    chk("R6", "lost cleared", lost, 0);
    plain_lines(2 * 337 + 3);
    chk("R6", "not lost after 2 fields", lost, 0);
    plain_lines(340);
    chk("R6", "lost after 3 fields", lost, 1);

    // R9 collision: crossing on the expiring hsync
    three = 0;
    drive_line(0, 1, 4, 6, 99);   // odd field, counter restarts
    for (int i = 0; i < 400; i++) begin
      if (m_lcnt == 335) break;
      drive_line(0, 1, 99, 0, 99);
    end
    drive_line(0, 1, 99, 0, 17);
    @(negedge clk); hs = 1; pos = '0; s_low = 1;
    @(negedge clk);
    chk("R9", "vsync wins", vs, 1);
    chk("R9", "no toggle", fld, 0);
    chk("R9", "not lost", lost, 0);
    hs = 0; pos = PW'(1); s_low = 1;
    drive_line(2, 1, 99, 0, 99);
    plain_lines(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule